// File: doc/BRIEF.md
# Vertical-Blanking Command Packet Injector

This block keeps one display-serial-interface command packet in a bank of eight 32-bit registers. While it is enabled, it sends that packet once in every vertical blanking interval. A host writes a header word and, for long packets, the payload words. The host then sets the enable and gives the total byte count. From then on, each vblank-start strobe makes the block send the packet again as a byte stream toward a lane serializer. The stream uses a valid/ready handshake.

The block builds the packet's integrity fields itself. The header's fourth byte is replaced by a Hamming-style ECC computed over the lower 24 header bits. A long packet's payload is followed by a 16-bit reflected CRC that the block accumulates as the payload bytes are accepted downstream. A long packet whose length does not fit the storage, or that disagrees with the byte count, is reported on an error output and is never sent. To shut the block down, the host clears the enable and then writes zero to every storage word.

Top module: `vbi_cmd_injector`

## Requirements
- R1: Transmitted bytes 0, 1 and 2 are header word bits [7:0], [15:8] and [23:16]. Byte 0 carries the virtual channel in bits 7:6 and the data type in bits 5:0. Bytes 1-2 are the 16-bit word count (or, for a short packet, its two parameters), low byte first.
- R2: Transmitted byte 3 is the XOR of one constant for each set bit among header bits 0..23. Header bits [31:24] as written are never sent. For bits 0..23 the constants are, in bit order: 07 0B 0D 0E 13 15 16 19 1A 1C 23 25 26 29 2A 2C 31 32 34 38 1F 2F 37 3B (hex).
- R3: A long packet ends with a 16-bit checksum over its payload bytes, sent low byte first. The checksum starts at FFFF. Each payload byte is taken LSB first, one bit at a time: if the register's bit 0 XOR the data bit is 1, the register becomes (register >> 1) XOR 8408; otherwise it becomes register >> 1.
- R4: Storage word 0 is the header. Payload byte k is read from word 1 + k/4, bits [8*(k mod 4)+7 : 8*(k mod 4)]. A write stores wr_data into the word selected by wr_addr.
- R5: With tx_bytes = 4 the packet is short and exactly 4 bytes are sent. With any other value it is long, and exactly 4 + word count + 2 bytes are sent.
- R6: cfg_err is high when the packet is long and either the word count exceeds 26 or tx_bytes differs from word count + 6. While cfg_err is high, a vblank strobe starts nothing.
- R7: After reset out_valid is low. A vblank strobe that arrives while the block is idle, enabled and free of error raises out_valid on the next cycle.
- R8: Each qualifying vblank strobe sends the stored packet again. No bytes are sent while enable is low.
- R9: out_data advances only on a cycle where out_valid and out_ready are both high. While out_ready is low, out_data holds steady.
- R10: Clearing enable during a transmission does not cut it short. The whole packet is still sent before out_valid falls.
- R11: A vblank strobe that arrives while a packet is being sent is ignored. It neither restarts the packet nor queues a second one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Storage write strobe |
| wr_addr | input | 3 | Storage word index |
| wr_data | input | 32 | Storage write data |
| enable | input | 1 | Allow a send on each vblank strobe |
| tx_bytes | input | 6 | Total packet bytes (4 means short) |
| vblank_start | input | 1 | One-cycle vertical blanking start strobe |
| out_ready | input | 1 | Serializer accepts the current byte |
| out_valid | output | 1 | A packet byte is presented |
| out_data | output | 8 | Packet byte |
| cfg_err | output | 1 | Stored packet length is unusable |

## Verification
The assertions check the handshake and framing rules on every cycle:
- a packet starts the cycle after a qualifying strobe;
- nothing starts from idle otherwise, including while the length is in error;
- data holds through a stall;
- once started, a packet runs to exactly the byte count captured at its start, whatever happens to the enable or to further strobes.

Only the bench's reference model can show that the byte contents are right: the header bytes, the computed ECC, the payload order and the checksum. It builds each expected packet from the words it wrote and compares the stream, under stalls, at the maximum 26-byte payload, with an empty payload, and after the shutdown sequence.

// File: rtl/vbi_pkg.sv
package vbi_pkg;

   localparam int HDR_BYTES = 4;
   localparam int CRC_BYTES = 2;
   localparam int ECC_COVER = 24;

   typedef enum logic [0:0] {ST_IDLE, ST_SEND} seq_state_e;

   typedef enum logic [1:0] {
      SRC_STORE,
      SRC_ECC,
      SRC_CRC_LO,
      SRC_CRC_HI
   } byte_src_e;

   // Parity weight of one covered header bit.
   function automatic logic [7:0] ecc_weight(input int unsigned bit_idx);
      logic [7:0] w;
      case (bit_idx)
         0:  w = 8'h07;
         1:  w = 8'h0B;
         2:  w = 8'h0D;
         3:  w = 8'h0E;
         4:  w = 8'h13;
         5:  w = 8'h15;
         6:  w = 8'h16;
         7:  w = 8'h19;
         8:  w = 8'h1A;
         9:  w = 8'h1C;
         10: w = 8'h23;
         11: w = 8'h25;
         12: w = 8'h26;
         13: w = 8'h29;
         14: w = 8'h2A;
         15: w = 8'h2C;
         16: w = 8'h31;
         17: w = 8'h32;
         18: w = 8'h34;
         19: w = 8'h38;
         20: w = 8'h1F;
         21: w = 8'h2F;
         22: w = 8'h37;
         23: w = 8'h3B;
         default: w = 8'h00;
      endcase
      return w;
   endfunction

   // One serial step of a right-shifting checksum register.
   function automatic logic [15:0] crc_bit_step(input logic [15:0] c,
                                                input logic d,
                                                input logic [15:0] poly);
      return (c[0] ^ d) ? ((c >> 1) ^ poly) : (c >> 1);
   endfunction

endpackage

// File: rtl/vbi_ecc.sv
module vbi_ecc
   import vbi_pkg::*;
#(
   parameter int COVER_BITS = ECC_COVER
) (
   input  logic [COVER_BITS-1:0] hdr,
   output logic [7:0]            ecc
);

   if (COVER_BITS != ECC_COVER) begin : g_bad_cover
      $error("vbi_ecc: header ECC covers exactly 24 bits");
   end

   logic [7:0] term [COVER_BITS];

   for (genvar i = 0; i < COVER_BITS; i++) begin : g_term
      assign term[i] = hdr[i] ? ecc_weight(i) : 8'h00;
   end

   always_comb begin
      ecc = 8'h00;
      for (int i = 0; i < COVER_BITS; i++) begin
         ecc = ecc ^ term[i];
      end
   end

endmodule

// File: rtl/vbi_crc16.sv
module vbi_crc16
   import vbi_pkg::*;
#(
   parameter logic [15:0] POLY = 16'h8408,
   parameter logic [15:0] SEED = 16'hFFFF,
   parameter int          DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              step,
   input  logic [DATA_W-1:0] din,
   output logic [15:0]       crc
);

   if (DATA_W < 1) begin : g_bad_width
      $error("vbi_crc16: DATA_W must be positive");
   end

   logic [15:0] chain [DATA_W+1];
   logic [15:0] crc_q;

   assign chain[0] = crc_q;

   // Unrolled LSB-first chain, one stage per input bit.
   for (genvar b = 0; b < DATA_W; b++) begin : g_stage
      assign chain[b+1] = crc_bit_step(chain[b], din[b], POLY);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= SEED;
      end else if (clear) begin
         crc_q <= SEED;
      end else if (step) begin
         crc_q <= chain[DATA_W];
      end
   end

   assign crc = crc_q;

endmodule

// File: rtl/vbi_reg_bank.sv
module vbi_reg_bank #(
   parameter int NUM_WORDS = 8,
   parameter int WORD_W    = 32,
   localparam int AW       = $clog2(NUM_WORDS),
   localparam int BPW      = WORD_W / 8,
   localparam int BSEL_W   = $clog2(BPW),
   localparam int BA_W     = AW + BSEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [BA_W-1:0]   rd_byte_addr,
   output logic [7:0]        rd_byte,
   output logic [23:0]       hdr_low
);

   if ((WORD_W % 8) != 0 || BPW < 4 || (BPW & (BPW - 1)) != 0) begin : g_bad_word
      $error("vbi_reg_bank: word must hold a power-of-two count of at least 4 bytes");
   end
   if (NUM_WORDS < 2 || (NUM_WORDS & (NUM_WORDS - 1)) != 0) begin : g_bad_depth
      $error("vbi_reg_bank: NUM_WORDS must be a power of two, at least 2");
   end

   logic [WORD_W-1:0] mem [NUM_WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < NUM_WORDS; w++) begin
            mem[w] <= '0;
         end
      end else if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   logic [AW-1:0]     rd_word;
   logic [BSEL_W-1:0] rd_lane;

   assign rd_word = rd_byte_addr[BA_W-1:BSEL_W];
   assign rd_lane = rd_byte_addr[BSEL_W-1:0];
   assign rd_byte = mem[rd_word][{rd_lane, 3'b000} +: 8];
   assign hdr_low = mem[0][23:0];

endmodule

// File: rtl/vbi_seq.sv
module vbi_seq
   import vbi_pkg::*;
#(
   parameter int IDX_W = 5,
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_req,
   input  logic [CNT_W-1:0] tot_in,
   input  logic             long_in,
   input  logic             out_ready,
   output logic             out_valid,
   output logic [IDX_W-1:0] idx,
   output byte_src_e        src,
   output logic             crc_clear,
   output logic             crc_step
);

   seq_state_e       st_q;
   logic [IDX_W-1:0] idx_q;
   logic [CNT_W-1:0] tot_q;
   logic             long_q;
   logic             fire;
   logic             last;
   logic             start;
   logic [CNT_W-1:0] pos;

   assign pos   = CNT_W'(idx_q);
   assign fire  = (st_q == ST_SEND) && out_ready;
   assign last  = (pos == tot_q - CNT_W'(1));
   assign start = (st_q == ST_IDLE) && start_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         idx_q  <= '0;
         tot_q  <= '0;
         long_q <= 1'b0;
      end else if (start) begin
         st_q   <= ST_SEND;
         idx_q  <= '0;
         tot_q  <= tot_in;
         long_q <= long_in;
      end else if (fire) begin
         if (last) begin
            st_q <= ST_IDLE;
         end else begin
            idx_q <= idx_q + IDX_W'(1);
         end
      end
   end

   always_comb begin
      src = SRC_STORE;
      if (pos == CNT_W'(HDR_BYTES - 1)) begin
         src = SRC_ECC;
      end else if (long_q && pos == tot_q - CNT_W'(CRC_BYTES)) begin
         src = SRC_CRC_LO;
      end else if (long_q && last) begin
         src = SRC_CRC_HI;
      end
   end

   assign crc_clear = start;
   assign crc_step  = fire && long_q && (pos >= CNT_W'(HDR_BYTES))
                      && (pos < tot_q - CNT_W'(CRC_BYTES));
   assign out_valid = (st_q == ST_SEND);
   assign idx       = idx_q;

endmodule

// File: rtl/vbi_cmd_injector.sv
module vbi_cmd_injector
   import vbi_pkg::*;
#(
   parameter int NUM_WORDS = 8,
   parameter int WORD_W    = 32,
   parameter int WC_W      = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [$clog2(NUM_WORDS)-1:0] wr_addr,
   input  logic [WORD_W-1:0]            wr_data,
   input  logic                         enable,
   input  logic [$clog2(NUM_WORDS*WORD_W/8+1)-1:0] tx_bytes,
   input  logic                         vblank_start,
   input  logic                         out_ready,
   output logic                         out_valid,
   output logic [7:0]                   out_data,
   output logic                         cfg_err
);

   localparam int TOTAL_BYTES = NUM_WORDS * WORD_W / 8;
   localparam int MAX_PAY     = TOTAL_BYTES - HDR_BYTES - CRC_BYTES;
   localparam int IDX_W       = $clog2(TOTAL_BYTES);
   localparam int CNT_W       = $clog2(TOTAL_BYTES + 1);

   if (WORD_W != 32 || WC_W != 16) begin : g_bad_fmt
      $error("vbi_cmd_injector: header layout needs 32-bit words and 16-bit count");
   end
   if (MAX_PAY < 1) begin : g_bad_room
      $error("vbi_cmd_injector: storage too small for a long packet");
   end

   logic [23:0]      hdr_low;
   logic [WC_W-1:0]  word_cnt;
   logic             is_long;
   logic [7:0]       store_byte;
   logic [7:0]       ecc_byte;
   logic [15:0]      crc_val;
   logic [IDX_W-1:0] idx;
   byte_src_e        src;
   logic             crc_clear;
   logic             crc_step;

   assign word_cnt = hdr_low[23:8];
   assign is_long  = (tx_bytes != CNT_W'(HDR_BYTES));
   assign cfg_err  = is_long && ((32'(word_cnt) > MAX_PAY) ||
                                 (32'(tx_bytes) != 32'(word_cnt) + HDR_BYTES + CRC_BYTES));

   vbi_reg_bank #(
      .NUM_WORDS (NUM_WORDS),
      .WORD_W    (WORD_W)
   ) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .rd_byte_addr (idx),
      .rd_byte      (store_byte),
      .hdr_low      (hdr_low)
   );

   vbi_ecc #(
      .COVER_BITS (ECC_COVER)
   ) u_ecc (
      .hdr (hdr_low),
      .ecc (ecc_byte)
   );

   vbi_crc16 #(
      .POLY   (16'h8408),
      .SEED   (16'hFFFF),
      .DATA_W (8)
   ) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (crc_clear),
      .step  (crc_step),
      .din   (store_byte),
      .crc   (crc_val)
   );

   vbi_seq #(
      .IDX_W (IDX_W),
      .CNT_W (CNT_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_req (vblank_start && enable && !cfg_err),
      .tot_in    (tx_bytes),
      .long_in   (is_long),
      .out_ready (out_ready),
      .out_valid (out_valid),
      .idx       (idx),
      .src       (src),
      .crc_clear (crc_clear),
      .crc_step  (crc_step)
   );

   always_comb begin
      case (src)
         SRC_ECC:    out_data = ecc_byte;
         SRC_CRC_LO: out_data = crc_val[7:0];
         SRC_CRC_HI: out_data = crc_val[15:8];
         default:    out_data = store_byte;
      endcase
   end

endmodule

// File: rtl/vbi_cmd_injector_chk.sv
module vbi_cmd_injector_chk #(
   parameter int CNT_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             vblank_start,
   input logic             enable,
   input logic             cfg_err,
   input logic [CNT_W-1:0] tx_bytes,
   input logic             out_valid,
   input logic             out_ready,
   input logic [7:0]       out_data
);

   logic             go;
   logic [CNT_W-1:0] sent_q;
   logic [CNT_W-1:0] want_q;
   logic             final_byte;

   assign go         = !out_valid && vblank_start && enable && !cfg_err;
   assign final_byte = out_valid && out_ready && (sent_q == want_q - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sent_q <= '0;
         want_q <= '0;
      end else if (go) begin
         sent_q <= '0;
         want_q <= tx_bytes;
      end else if (out_valid && out_ready) begin
         sent_q <= sent_q + CNT_W'(1);
      end
   end

   a_r7_start_next: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> out_valid);

   a_r8_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_valid && !(vblank_start && enable && !cfg_err)) |=> !out_valid);

   a_r6_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_valid && cfg_err) |=> !out_valid);

   a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   a_r10_runs_out: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !final_byte) |=> out_valid);

   a_r5_ends_exact: assert property (@(posedge clk) disable iff (!rst_n)
      final_byte |=> !out_valid);

   a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && vblank_start && !out_ready) |=> $stable(out_data));

endmodule

bind vbi_cmd_injector vbi_cmd_injector_chk #(
   .CNT_W ($clog2(NUM_WORDS*WORD_W/8+1))
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .vblank_start (vblank_start),
   .enable       (enable),
   .cfg_err      (cfg_err),
   .tx_bytes     (tx_bytes),
   .out_valid    (out_valid),
   .out_ready    (out_ready),
   .out_data     (out_data)
);

// File: tb/vbi_cmd_injector_test.sv
module vbi_cmd_injector_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        enable = 1'b0;
   logic [5:0]  tx_bytes = 6'd4;
   logic        vblank_start = 1'b0;
   logic        out_ready = 1'b1;
   logic        out_valid;
   logic [7:0]  out_data;
   logic        cfg_err;

   always #5 clk = ~clk;

   vbi_cmd_injector uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .enable(enable), .tx_bytes(tx_bytes),
      .vblank_start(vblank_start), .out_ready(out_ready),
      .out_valid(out_valid), .out_data(out_data), .cfg_err(cfg_err)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // Reference model built from the requirement text.
   int ecc_tab [24] = '{8'h07, 8'h0B, 8'h0D, 8'h0E, 8'h13, 8'h15, 8'h16, 8'h19,
                        8'h1A, 8'h1C, 8'h23, 8'h25, 8'h26, 8'h29, 8'h2A, 8'h2C,
                        8'h31, 8'h32, 8'h34, 8'h38, 8'h1F, 8'h2F, 8'h37, 8'h3B};
   bit [31:0] m_mem [8];
   int        q [$];
   string     tq [$];
   bit        m_busy = 1'b0;
   int        bursts = 0;
   int        bytes_seen = 0;
   bit        prev_valid = 1'b0;

   function automatic int m_ecc(input bit [23:0] h);
      int e = 0;
      for (int i = 0; i < 24; i++) if (h[i]) e = e ^ ecc_tab[i];
      return e;
   endfunction

   function automatic bit m_err();
      int wc = int'(m_mem[0][23:8]);
      int tb = int'(tx_bytes);
      return (tb != 4) && ((wc > 26) || (tb != wc + 6));
   endfunction

   function automatic void m_build();
      int wc = int'(m_mem[0][23:8]);
      int crc = 16'hFFFF;
      q.delete();
      tq.delete();
      for (int b = 0; b < 3; b++) begin
         q.push_back(int'(m_mem[0][8*b +: 8]));
         tq.push_back("R1 header byte");
      end
      q.push_back(m_ecc(m_mem[0][23:0]));
      tq.push_back("R2 ecc byte");
      if (tx_bytes != 6'd4) begin
         for (int k = 0; k < wc; k++) begin
            int v = int'(m_mem[1 + k/4][8*(k%4) +: 8]);
            q.push_back(v);
            tq.push_back("R4 payload byte");
            for (int i = 0; i < 8; i++) begin
               if (((crc ^ (v >> i)) & 1) != 0) crc = (crc >> 1) ^ 16'h8408;
               else crc = crc >> 1;
            end
         end
         q.push_back(crc & 8'hFF);
         tq.push_back("R3 checksum low");
         q.push_back((crc >> 8) & 8'hFF);
         tq.push_back("R3 checksum high");
      end
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 1'b0;
         q.delete();
         tq.delete();
         for (int w = 0; w < 8; w++) m_mem[w] = '0;
      end else begin
         bit st;
         if (out_valid && out_ready) bytes_seen++;
         st = !m_busy && vblank_start && enable && !m_err();
         if (m_busy && out_ready) begin
            void'(q.pop_front());
            void'(tq.pop_front());
            if (q.size() == 0) m_busy = 1'b0;
         end else if (st) begin
            m_build();
            m_busy = 1'b1;
         end
         if (wr_en) m_mem[wr_addr] = wr_data;
      end
   end

   // Compare against the model on every cycle, away from the clock edge.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(out_valid == m_busy, m_busy ? "R7 packet start/continue" : "R8 unexpected send",
             longint'(out_valid), longint'(m_busy));
         if (out_valid && m_busy && q.size() > 0)
            chk(int'(out_data) == q[0], tq[0], longint'(out_data), longint'(q[0]));
         chk(cfg_err == m_err(), "R6 error flag", longint'(cfg_err), longint'(m_err()));
         if (out_valid && !prev_valid) bursts++;
         prev_valid = out_valid;
      end
   end

   // Downstream back-pressure: always ready, or a pseudo-random pattern.
   bit        stall_en = 1'b0;
   bit [15:0] lf = 16'hACE1;
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (stall_en) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            out_ready = lf[0];
         end else begin
            out_ready = 1'b1;
         end
      end
   end

   task automatic wr(input int a, input bit [31:0] d);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic vbl();
      @(posedge clk); #1;
      vblank_start = 1'b1;
      @(posedge clk); #1;
      vblank_start = 1'b0;
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic at_negedge();
      @(negedge clk);
   endtask

   task automatic finish_up();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #1_000_000;
      chk(1'b0, "watchdog expired", 0, 1);
      finish_up();
   end

   initial begin
      int b0;
      int s0;
      wait_n(3);
      at_negedge();
      chk(out_valid == 1'b0, "R7 reset state", longint'(out_valid), 0);
      rst_n = 1'b1;
      wait_n(2);
      at_negedge();
      chk(out_valid == 1'b0 && cfg_err == 1'b0, "R7 idle after reset",
          longint'({out_valid, cfg_err}), 0);

      // R1/R2/R5: short packet with virtual channel 3, plus nonzero bits [31:24].
      wr(0, 32'hEE_3412_C5);
      enable = 1'b1; tx_bytes = 6'd4;
      b0 = bursts; s0 = bytes_seen;
      vbl(); wait_n(10);
      at_negedge();
      chk(bursts == b0 + 1, "R8 one burst per vblank", bursts - b0, 1);
      chk(bytes_seen - s0 == 4, "R5 short length", bytes_seen - s0, 4);

      // R3/R4/R9: long packet with 5 payload bytes under back-pressure.
      wr(1, 32'h44332211);
      wr(2, 32'h00000055);
      wr(0, 32'hAB_0005_29);
      tx_bytes = 6'd11;
      stall_en = 1'b1;
      b0 = bursts; s0 = bytes_seen;
      vbl(); wait_n(60);
      at_negedge();
      chk(bytes_seen - s0 == 11, "R5 long length", bytes_seen - s0, 11);

      // R8: the same packet is replayed on every qualifying vblank.
      stall_en = 1'b0;
      b0 = bursts;
      for (int i = 0; i < 3; i++) begin
         vbl(); wait_n(20);
      end
      at_negedge();
      chk(bursts == b0 + 3, "R8 repeated per frame", bursts - b0, 3);

      // R8: no send while disabled.
      enable = 1'b0;
      b0 = bursts;
      vbl(); wait_n(20);
      at_negedge();
      chk(bursts == b0, "R8 disabled no send", bursts - b0, 0);

      // R10: clearing enable mid-packet still finishes the packet.
      enable = 1'b1;
      b0 = bursts; s0 = bytes_seen;
      vbl(); wait_n(2);
      enable = 1'b0;
      wait_n(20);
      at_negedge();
      chk(bytes_seen - s0 == 11 && bursts == b0 + 1, "R10 packet completes",
          bytes_seen - s0, 11);

      // R11: a strobe during sending is ignored.
      enable = 1'b1; stall_en = 1'b1;
      b0 = bursts; s0 = bytes_seen;
      vbl(); wait_n(3);
      vbl(); wait_n(80);
      at_negedge();
      chk(bursts == b0 + 1, "R11 strobe while busy ignored", bursts - b0, 1);
      chk(bytes_seen - s0 == 11, "R11 no restart", bytes_seen - s0, 11);
      stall_en = 1'b0;

      // R6: word count above the limit.
      wr(0, 32'h00_001B_39);
      tx_bytes = 6'd33;
      wait_n(1);
      at_negedge();
      chk(cfg_err == 1'b1, "R6 oversize flagged", longint'(cfg_err), 1);
      b0 = bursts;
      vbl(); wait_n(20);
      at_negedge();
      chk(bursts == b0, "R6 oversize not sent", bursts - b0, 0);

      // R6: byte count disagrees with the word count.
      wr(0, 32'h00_0005_29);
      tx_bytes = 6'd12;
      wait_n(1);
      at_negedge();
      chk(cfg_err == 1'b1, "R6 count mismatch flagged", longint'(cfg_err), 1);

      // R4/R3 boundary: full 26-byte payload.
      for (int w = 1; w < 8; w++) wr(w, 32'h01020304 * w + 32'h9C5A0F00);
      wr(0, 32'h00_001A_79);
      tx_bytes = 6'd32;
      b0 = bursts; s0 = bytes_seen;
      vbl(); wait_n(45);
      at_negedge();
      chk(bytes_seen - s0 == 32, "R5 maximum length", bytes_seen - s0, 32);

      // R3 boundary: empty long payload sends only the seed checksum.
      wr(0, 32'h00_0000_39);
      tx_bytes = 6'd6;
      s0 = bytes_seen;
      vbl(); wait_n(15);
      at_negedge();
      chk(bytes_seen - s0 == 6, "R3 empty payload length", bytes_seen - s0, 6);

      // R4: shutdown sequence, then a zero header is what remains.
      enable = 1'b0;
      for (int w = 0; w < 8; w++) wr(w, 32'h0);
      tx_bytes = 6'd4;
      enable = 1'b1;
      s0 = bytes_seen;
      vbl(); wait_n(10);
      at_negedge();
      chk(bytes_seen - s0 == 4, "R4 cleared storage short", bytes_seen - s0, 4);

      wait_n(5);
      finish_up();
   end

endmodule